// File: doc/BRIEF.md
# Overload Fault Timer with Hiccup Restart

This block decides when a switching power stage has been overloaded for too long and how it may start again. A fault timer, modelled as an up/down counter, climbs by one each clock while the peak-current-limit comparator reports the limit and no normal end-of-cycle PWM reset arrives in the same clock. In every other active cycle it falls by one at the same rate. When the counter reaches its limit while the overload is still present, gate pulses stop in the very next cycle.

The restart policy depends on a strap input. In auto-recovery mode the block enters a hiccup phase. It waits for the supply to sag below its minimum and turns the startup current source on. Each time the supply climbs back to its turn-on level, the source is shut off and one completed charge cycle is counted. Only after the third completion does switching resume, through a soft-start that ramps the peak-current limit from zero to full scale. In latch mode the fault is held until the synchronous power-down reset. An undervoltage report during switching ends any timer run at once and sends the block into hiccup in either mode. Supply charge and discharge are seen only as digital events.

Top module: `ovl_hiccup_ctrl`

## Requirements
- R1: While pulses are enabled, `timer_val` rises by one per cycle when `ilim_flag`=1 and `pwm_reset`=0, saturating at `TIMER_LIMIT`. Otherwise it falls by one per cycle and stops at 0.
- R2: When `ilim_flag` and `pwm_reset` are both 1 in the same cycle, the timer falls, as if the limit flag were absent.
- R3: In the cycle where an up-count takes the timer from `TIMER_LIMIT`-1 to `TIMER_LIMIT`, `pulse_en` goes to 0 on that same clock edge. `timer_val` equal to `TIMER_LIMIT` never coincides with `pulse_en`=1.
- R4: With `latch_mode`=0, a timer fault enters hiccup. In hiccup, `hv_src_en` turns on when `uv_flag`=1 and turns off on the next `supply_on`=1, which counts one completed charge. On the third completion, pulses restart in soft-start.
- R5: With `latch_mode`=1, a timer fault sets `fault_latched`=1 and clears `pulse_en` and `hv_src_en`. They stay that way regardless of inputs until `rst`.
- R6: `uv_flag`=1 while pulses are enabled clears `pulse_en` on the next edge and enters hiccup with `hv_src_en`=1, in either mode. This takes precedence over a timer fault in the same cycle.
- R7: In soft-start, `ilim_level` starts at 0 and rises by one every `SS_STEP` cycles. One cycle after it reaches all-ones, the block runs with `ilim_level` held at all-ones.
- R8: On every entry into soft-start, the timer and the hiccup completion count restart from 0.
- R9: After `rst`, `pulse_en`=0, `hv_src_en`=1, `fault_latched`=0, `timer_val`=0 and `ilim_level`=0. The first `supply_on`=1 starts soft-start.
- R10: While pulses are disabled, `timer_val` holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high power-down reset |
| ilim_flag | input | 1 | Peak-current limit reached this cycle |
| pwm_reset | input | 1 | Normal per-cycle PWM turn-off event |
| uv_flag | input | 1 | Supply below its minimum level |
| supply_on | input | 1 | Supply has reached its turn-on level |
| latch_mode | input | 1 | Strap: 1 latches on fault, 0 auto-recovers |
| pulse_en | output | 1 | Gate pulses permitted |
| hv_src_en | output | 1 | Startup current source enabled |
| fault_latched | output | 1 | Latched-off fault indication |
| timer_val | output | clog2(TIMER_LIMIT+1) | Fault timer count |
| ilim_level | output | LVL_W | Peak-current limit scale (soft-start ramp) |

## Verification
The hardest state to reach is the third completed recharge in auto-recovery. It needs a timer fault, then an undervoltage report, then a turn-on event, and that pair repeated three times, with no reset in between. The stimulus shortens the limit to a few tens of cycles and biases the limit flag high for whole segments so that the counter outruns the down-counts. Sparse random undervoltage and turn-on events then walk the hiccup sequence many times. Segments alternate the strap between the two modes, so both latch and restart paths are covered, along with undervoltage landing inside soft-start.

// File: rtl/ovl_pkg.sv
package ovl_pkg;

    typedef enum logic [2:0] {
        ST_CHARGE = 3'd0,
        ST_SOFT   = 3'd1,
        ST_RUN    = 3'd2,
        ST_HICCUP = 3'd3,
        ST_LOCK   = 3'd4
    } mode_e;

    typedef struct packed {
        logic gate_en;
        logic hv_en;
        logic locked;
    } drive_t;

    function automatic logic is_active(mode_e m);
        return (m == ST_SOFT) || (m == ST_RUN);
    endfunction

    function automatic drive_t decode_mode(mode_e m, logic recharge);
        drive_t d;
        d.gate_en = is_active(m);
        d.hv_en   = (m == ST_CHARGE) || ((m == ST_HICCUP) && recharge);
        d.locked  = (m == ST_LOCK);
        return d;
    endfunction

endpackage

// File: rtl/ovl_fault_timer.sv
module ovl_fault_timer #(
    parameter int THRESH = 20,
    parameter int TW     = $clog2(THRESH + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          run,
    input  logic          clear,
    input  logic          ilim,
    input  logic          pwm_rst,
    output logic [TW-1:0] cnt,
    output logic          expire
);
    localparam logic [TW-1:0] TOP = TW'(THRESH);

    logic up;
    assign up     = ilim && !pwm_rst;
    assign expire = run && up && (cnt == TW'(THRESH - 1));

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            cnt <= '0;
        end else if (run) begin
            if (up && cnt != TOP)
                cnt <= cnt + TW'(1);
            else if (!up && cnt != '0)
                cnt <= cnt - TW'(1);
        end
    end

    // R1: up-step while limit holds and not saturated
    a_r1_up_step: assert property (@(posedge clk) disable iff (rst)
        (run && !clear && ilim && !pwm_rst && cnt != TOP) |=> (cnt == $past(cnt) + TW'(1)));

    // R2: PWM reset beats a simultaneous limit flag
    a_r2_pwm_wins: assert property (@(posedge clk) disable iff (rst)
        (run && !clear && ilim && pwm_rst && cnt != '0) |=> (cnt == $past(cnt) - TW'(1)));

    // R10: frozen while not switching
    a_r10_frozen: assert property (@(posedge clk) disable iff (rst)
        (!run && !clear) |=> $stable(cnt));

endmodule

// File: rtl/ovl_softstart.sv
module ovl_softstart #(
    parameter int LVL_W   = 8,
    parameter int SS_STEP = 1961
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    output logic [LVL_W-1:0] level,
    output logic             full
);
    localparam int STEP_W = $clog2(SS_STEP + 1);
    localparam logic [LVL_W-1:0] LMAX = '1;

    logic [STEP_W-1:0] step;

    assign full = (level == LMAX);

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            step  <= '0;
            level <= '0;
        end else if (!full) begin
            if (step == STEP_W'(SS_STEP - 1)) begin
                step  <= '0;
                level <= level + LVL_W'(1);
            end else begin
                step <= step + STEP_W'(1);
            end
        end
    end

    // R7: ramp never falls while enabled
    a_r7_ramp_rises: assert property (@(posedge clk) disable iff (rst)
        (en && $past(en) && !$past(rst)) |-> (level >= $past(level)));

endmodule

// File: rtl/ovl_restart_fsm.sv
module ovl_restart_fsm
    import ovl_pkg::*;
#(
    parameter int HICCUP_N = 3
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  expire,
    input  logic  uv,
    input  logic  supply_on,
    input  logic  latch_mode,
    input  logic  ramp_full,
    output mode_e mode,
    output logic  recharge,
    output logic  resume
);
    localparam int HC_W = (HICCUP_N > 1) ? $clog2(HICCUP_N) : 1;

    mode_e            mode_nx;
    logic             rechg_nx;
    logic [HC_W-1:0]  hcnt, hcnt_nx;

    always_comb begin
        mode_nx  = mode;
        rechg_nx = recharge;
        hcnt_nx  = hcnt;
        case (mode)
            ST_CHARGE: if (supply_on) mode_nx = ST_SOFT;
            ST_SOFT, ST_RUN: begin
                if (uv) begin
                    mode_nx  = ST_HICCUP;
                    rechg_nx = 1'b1;
                    hcnt_nx  = '0;
                end else if (expire) begin
                    mode_nx  = latch_mode ? ST_LOCK : ST_HICCUP;
                    rechg_nx = 1'b0;
                    hcnt_nx  = '0;
                end else if (mode == ST_SOFT && ramp_full) begin
                    mode_nx = ST_RUN;
                end
            end
            ST_HICCUP: begin
                if (!recharge) begin
                    if (uv) rechg_nx = 1'b1;
                end else if (supply_on) begin
                    rechg_nx = 1'b0;
                    if (hcnt == HC_W'(HICCUP_N - 1)) begin
                        mode_nx = ST_SOFT;
                        hcnt_nx = '0;
                    end else begin
                        hcnt_nx = hcnt + HC_W'(1);
                    end
                end
            end
            default: mode_nx = ST_LOCK;
        endcase
    end

    assign resume = (mode_nx == ST_SOFT) && (mode != ST_SOFT);

    always_ff @(posedge clk) begin
        if (rst) begin
            mode     <= ST_CHARGE;
            recharge <= 1'b0;
            hcnt     <= '0;
        end else begin
            mode     <= mode_nx;
            recharge <= rechg_nx;
            hcnt     <= hcnt_nx;
        end
    end

    // R5: lock is absorbing until reset
    a_r5_lock_hold: assert property (@(posedge clk) disable iff (rst)
        (mode == ST_LOCK) |=> (mode == ST_LOCK));

    // R6: undervoltage while switching always enters hiccup
    a_r6_uv_hiccup: assert property (@(posedge clk) disable iff (rst)
        (is_active(mode) && uv) |=> (mode == ST_HICCUP && recharge));

    // R4: completion count stays below the divide ratio
    a_r4_count_range: assert property (@(posedge clk) disable iff (rst)
        hcnt < HC_W'(HICCUP_N) || HICCUP_N == 1);

endmodule

// File: rtl/ovl_hiccup_ctrl.sv
module ovl_hiccup_ctrl
    import ovl_pkg::*;
#(
    parameter  int TIMER_LIMIT = 5_000_000,
    parameter  int HICCUP_N    = 3,
    parameter  int LVL_W       = 8,
    parameter  int SS_STEP     = 1961,
    localparam int TW          = $clog2(TIMER_LIMIT + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ilim_flag,
    input  logic             pwm_reset,
    input  logic             uv_flag,
    input  logic             supply_on,
    input  logic             latch_mode,
    output logic             pulse_en,
    output logic             hv_src_en,
    output logic             fault_latched,
    output logic [TW-1:0]    timer_val,
    output logic [LVL_W-1:0] ilim_level
);
    mode_e            mode;
    logic             recharge, resume, expire, ramp_full;
    logic [LVL_W-1:0] ramp_lvl;
    drive_t           drv;

    ovl_fault_timer #(.THRESH(TIMER_LIMIT), .TW(TW)) u_timer (
        .clk(clk), .rst(rst), .run(is_active(mode)), .clear(resume),
        .ilim(ilim_flag), .pwm_rst(pwm_reset), .cnt(timer_val), .expire(expire)
    );

    ovl_softstart #(.LVL_W(LVL_W), .SS_STEP(SS_STEP)) u_ramp (
        .clk(clk), .rst(rst), .en(mode == ST_SOFT), .level(ramp_lvl), .full(ramp_full)
    );

    ovl_restart_fsm #(.HICCUP_N(HICCUP_N)) u_fsm (
        .clk(clk), .rst(rst), .expire(expire), .uv(uv_flag), .supply_on(supply_on),
        .latch_mode(latch_mode), .ramp_full(ramp_full),
        .mode(mode), .recharge(recharge), .resume(resume)
    );

    assign drv           = decode_mode(mode, recharge);
    assign pulse_en      = drv.gate_en;
    assign hv_src_en     = drv.hv_en;
    assign fault_latched = drv.locked;
    assign ilim_level    = (mode == ST_RUN) ? '1 : ramp_lvl;

    // R3: a completed timer never coexists with gate pulses
    a_r3_done_gates_off: assert property (@(posedge clk) disable iff (rst)
        (timer_val == TW'(TIMER_LIMIT)) |-> !pulse_en);

    // R8: every restart of pulses begins with an empty timer
    a_r8_resume_clear: assert property (@(posedge clk) disable iff (rst)
        $rose(pulse_en) |-> (timer_val == '0 && ilim_level == '0));

endmodule

// File: tb/ovl_hiccup_ctrl_tb.sv
module ovl_hiccup_ctrl_tb;
    localparam int LIM = 20;
    localparam int HN  = 3;
    localparam int LW  = 3;
    localparam int SS  = 2;
    localparam int TW  = $clog2(LIM + 1);
    localparam int LMAX = (1 << LW) - 1;

    logic clk = 1'b0;
    logic rst, ilim_flag, pwm_reset, uv_flag, supply_on, latch_mode;
    logic pulse_en, hv_src_en, fault_latched;
    logic [TW-1:0] timer_val;
    logic [LW-1:0] ilim_level;

    int n_chk = 0, n_bad = 0;
    bit finished = 0;

    // reference state: 0 charge, 1 soft, 2 run, 3 hiccup, 4 lock
    int m_mode, m_tmr, m_hc, m_lvl, m_step;
    bit m_chg, ev_resume, ev_uvstop;

    always #5 clk = ~clk;

    ovl_hiccup_ctrl #(.TIMER_LIMIT(LIM), .HICCUP_N(HN), .LVL_W(LW), .SS_STEP(SS)) u_dut (
        .clk(clk), .rst(rst), .ilim_flag(ilim_flag), .pwm_reset(pwm_reset),
        .uv_flag(uv_flag), .supply_on(supply_on), .latch_mode(latch_mode),
        .pulse_en(pulse_en), .hv_src_en(hv_src_en), .fault_latched(fault_latched),
        .timer_val(timer_val), .ilim_level(ilim_level)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic model_next(input bit r, input bit il, input bit pr,
                              input bit uv, input bit so, input bit lm);
        int nm, nhc;
        bit nchg, act, up, expire, resume;
        ev_resume = 0;
        ev_uvstop = 0;
        if (r) begin
            m_mode = 0; m_tmr = 0; m_chg = 0; m_hc = 0; m_lvl = 0; m_step = 0;
            return;
        end
        act    = (m_mode == 1) || (m_mode == 2);
        up     = il && !pr;
        expire = act && up && (m_tmr == LIM - 1);
        nm = m_mode; nchg = m_chg; nhc = m_hc;
        case (m_mode)
            0: if (so) nm = 1;
            1, 2: begin
                if (uv) begin nm = 3; nchg = 1; nhc = 0; end
                else if (expire) begin nm = lm ? 4 : 3; nchg = 0; nhc = 0; end
                else if (m_mode == 1 && m_lvl == LMAX) nm = 2;
            end
            3: begin
                if (!m_chg) begin
                    if (uv) nchg = 1;
                end else if (so) begin
                    nchg = 0;
                    if (m_hc == HN - 1) begin nm = 1; nhc = 0; end
                    else nhc = m_hc + 1;
                end
            end
            default: nm = 4;
        endcase
        resume = (nm == 1) && (m_mode != 1);
        if (resume) m_tmr = 0;
        else if (act) begin
            if (up && m_tmr != LIM) m_tmr++;
            else if (!up && m_tmr != 0) m_tmr--;
        end
        if (m_mode != 1) begin m_lvl = 0; m_step = 0; end
        else if (m_lvl != LMAX) begin
            if (m_step == SS - 1) begin m_step = 0; m_lvl++; end
            else m_step++;
        end
        ev_resume = resume;
        ev_uvstop = act && uv;
        m_mode = nm; m_chg = nchg; m_hc = nhc;
    endtask

    task automatic compare_all();
        bit act = (m_mode == 1) || (m_mode == 2);
        chk("R3 pulse_en", int'(pulse_en), int'(act));
        chk("R4 hv_src_en", int'(hv_src_en), int'(m_mode == 0 || (m_mode == 3 && m_chg)));
        chk("R5 fault_latched", int'(fault_latched), int'(m_mode == 4));
        chk(act ? "R1 timer_val" : "R10 timer_val held", int'(timer_val), m_tmr);
        chk("R7 ilim_level", int'(ilim_level), (m_mode == 2) ? LMAX : m_lvl);
        if (ev_resume) chk("R8 timer cleared on resume", int'(timer_val), 0);
        if (ev_uvstop) chk("R6 uv stops pulses", int'(pulse_en), 0);
    endtask

    task automatic apply(input bit r, input bit il, input bit pr,
                         input bit uv, input bit so, input bit lm);
        rst = r; ilim_flag = il; pwm_reset = pr; uv_flag = uv;
        supply_on = so; latch_mode = lm;
        model_next(r, il, pr, uv, so, lm);
        @(negedge clk);
        compare_all();
    endtask

    initial begin
        void'($urandom(32'd4021));
        rst = 1; ilim_flag = 0; pwm_reset = 0; uv_flag = 0; supply_on = 0; latch_mode = 0;
        model_next(1, 0, 0, 0, 0, 0);
        @(negedge clk);
        apply(1, 0, 0, 0, 0, 0);
        // R9: reset state
        chk("R9 pulse_en", int'(pulse_en), 0);
        chk("R9 hv_src_en", int'(hv_src_en), 1);
        chk("R9 fault_latched", int'(fault_latched), 0);
        chk("R9 timer_val", int'(timer_val), 0);
        chk("R9 ilim_level", int'(ilim_level), 0);
        // R9: first supply_on starts soft-start
        apply(0, 0, 0, 0, 1, 0);
        chk("R9 soft-start begins", int'(pulse_en), 1);
        // R1: five up-counts
        for (int i = 0; i < 5; i++) apply(0, 1, 0, 0, 0, 0);
        chk("R1 directed up count", int'(timer_val), 5);
        // R2: limit with PWM reset counts down
        for (int i = 0; i < 2; i++) apply(0, 1, 1, 0, 0, 0);
        chk("R2 pwm reset wins", int'(timer_val), 3);
        // R3/R5: run timer to completion in latch mode
        for (int i = 0; i < LIM; i++) apply(0, 1, 0, 0, 0, 1);
        chk("R3 completion stops pulses", int'(pulse_en), 0);
        chk("R5 latched", int'(fault_latched), 1);
        for (int i = 0; i < 6; i++) apply(0, i[0], 0, 1, 1, i[1]);
        chk("R5 still latched under activity", int'(fault_latched), 1);
        chk("R10 timer frozen at limit", int'(timer_val), LIM);

        for (int seg = 0; seg < 8; seg++) begin
            int p_il;
            bit lm;
            lm = seg[0];
            p_il = (seg % 4 == 0) ? 95 : (seg % 4 == 1) ? 75 : (seg % 4 == 2) ? 50 : 15;
            apply(1, 0, 0, 0, 0, lm);
            apply(1, 0, 0, 0, 0, lm);
            for (int c = 0; c < 2000; c++) begin
                apply(0, ($urandom % 100) < p_il, ($urandom % 100) < 10,
                      ($urandom % 100) < 2, ($urandom % 100) < 25, lm);
            end
        end
        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule